// File: doc/BRIEF.md
# Paged Open-Drain GPIO Register Bank

This block is the register front end of a 48-line digital I/O controller. A host writes and reads byte-wide registers through an 8-bit address, an 8-bit write bus and separate read and write strobes. Six port registers drive open-drain pads, one bit per line. A 1 makes the pad sink current, pulling it low. A 0 releases the pad so that it can serve as an input. A port read returns the inverted level of the synchronized pad. As a result, an output sinking current reads back as 1, and a released pad that is pulled high reads as 0.

One combined control register holds a write lock for each port and a two-bit page field. A window of three addresses above the control register is passed to an external interrupt unit whenever a non-zero page is selected. The page value and the register index within the window travel with the strobes. The interrupt unit also supplies the pending byte, which the bank only reads. The synchronized pad levels are sent on to the interrupt unit for edge detection.

Top module: `gpio_paged_bank`

## Requirements
- R1: After reset every pad output-enable is 0, every lock bit is clear, and the page field is 0, so a read of address 0x7 returns 0x00.
- R2: A write to address p (0x0 to 0x5) loads port register p, and bit n of that register drives `pad_oe_o[8*p+n]`, where 1 means sink low.
- R3: A read of address p (0x0 to 0x5) returns the bitwise inverse of the synchronized pad levels of port p. A change at `pad_in_i` first shows in read data captured on the third rising edge after the change.
- R4: Address 0x7 holds the lock bits in bits 5:0, one per port (bit p locks port p), and the page in bits 7:6. Lock bits can be both set and cleared, and a read returns the value last written.
- R5: While the lock bit of port p is 1, writes to address p leave that port's outputs unchanged, and other unlocked ports still accept writes.
- R6: A read of address 0x6 returns `pend_i`. A write to 0x6 changes no port, lock or page state.
- R7: With page 1, 2 or 3 selected, an access to 0x8 to 0xA raises `pg_wr_o` or `pg_rd_o` in the same cycle. It also presents the page on `pg_sel_o`, the offset (0 to 2) on `pg_idx_o` and the write byte on `pg_wdata_o`, and read data returns `pg_rdata_i`.
- R8: With page 0 selected, accesses to 0x8 to 0xA raise no window strobe and read as 0x00.
- R9: Addresses 0x0B to 0xFF read as 0x00, and writes to them change no state.
- R10: `rdata_o` is loaded on the rising edge that samples `rd_i` high, and it holds its value in every cycle without a read.
- R11: `pin_sync_o` follows `pad_in_i` through exactly two register stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one access per cycle high |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| pad_in_i | input | 48 | Sampled pad levels |
| pad_oe_o | output | 48 | Per-line sink enable (1 = drive low) |
| pin_sync_o | output | 48 | Synchronized pad levels for edge detection |
| pend_i | input | 8 | Pending byte from the interrupt unit |
| pg_rdata_i | input | 8 | Read data from the interrupt unit's paged registers |
| pg_wr_o | output | 1 | Paged window write strobe |
| pg_rd_o | output | 1 | Paged window read strobe |
| pg_sel_o | output | 2 | Selected page |
| pg_idx_o | output | 2 | Register offset inside the window |
| pg_wdata_o | output | 8 | Write data to the paged register |

## Verification
The hardest case to reach is a read that lands exactly while a pad change is still inside the synchronizer. Only a precise cycle count separates the stale value from the fresh one. The bench closes an open-drain loop around the pads and forces one port low from outside. It then issues three back-to-back reads starting in the very next cycle, expecting the old value twice and the new value once. The lock case is reached by writing a locked port with data that differs from its held value, while a neighbouring unlocked port is written in the same phase.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PORTS     = 6;
  localparam int PORT_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int ADDR_PEND = PORTS;
  localparam int ADDR_PGLK = PORTS + 1;
  localparam int ADDR_WIN  = PORTS + 2;
  localparam int WIN_N     = 3;
  localparam int ADDR_LAST = ADDR_WIN + WIN_N - 1;

  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_POL  = 2'd1,
    PG_ENA  = 2'd2,
    PG_IID  = 2'd3
  } page_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  // released pads float high, so reset to all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int NPORT = PORTS,
  parameter int IW    = $clog2(NPORT)
) (
  input  logic [AW-1:0] addr_i,
  input  page_e         page_i,
  output logic          port_hit_o,
  output logic [IW-1:0] port_idx_o,
  output logic          pend_hit_o,
  output logic          pglk_hit_o,
  output logic          win_hit_o,
  output logic [1:0]    win_idx_o
);
  always_comb begin
    port_hit_o = addr_i < AW'(NPORT);
    port_idx_o = addr_i[IW-1:0];
    pend_hit_o = addr_i == AW'(ADDR_PEND);
    pglk_hit_o = addr_i == AW'(ADDR_PGLK);
    win_hit_o  = (addr_i >= AW'(ADDR_WIN)) && (addr_i <= AW'(ADDR_LAST))
                 && (page_i != PG_NONE);
    win_idx_o  = 2'(addr_i[1:0] - 2'(ADDR_WIN));
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int NPORT = 6,
  parameter int PW    = 8,
  parameter int IW    = $clog2(NPORT)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IW-1:0]       idx_i,
  input  logic [PW-1:0]       wdata_i,
  input  logic [NPORT-1:0]    lock_i,
  output logic [NPORT*PW-1:0] oe_o
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [PW-1:0] out_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         out_q <= '0;
      else if (wr_en_i && idx_i == IW'(p) && !lock_i[p])   out_q <= wdata_i;
    end

    assign oe_o[p*PW +: PW] = out_q;
  end
endmodule

// File: rtl/gpio_paged_bank.sv
module gpio_paged_bank
  import gpio_bank_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int NPORT = PORTS,
  parameter int PW    = PORT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       addr_i,
  input  logic [PW-1:0]       wdata_i,
  input  logic                wr_i,
  input  logic                rd_i,
  output logic [PW-1:0]       rdata_o,
  input  logic [NPORT*PW-1:0] pad_in_i,
  output logic [NPORT*PW-1:0] pad_oe_o,
  output logic [NPORT*PW-1:0] pin_sync_o,
  input  logic [PW-1:0]       pend_i,
  input  logic [PW-1:0]       pg_rdata_i,
  output logic                pg_wr_o,
  output logic                pg_rd_o,
  output logic [1:0]          pg_sel_o,
  output logic [1:0]          pg_idx_o,
  output logic [PW-1:0]       pg_wdata_o
);
  localparam int NLINE = NPORT * PW;
  localparam int IW    = $clog2(NPORT);

  page_e            page_q;
  logic [NPORT-1:0] lock_q;
  logic             port_hit, pend_hit, pglk_hit, win_hit;
  logic [IW-1:0]    port_idx;
  logic [1:0]       win_idx;
  logic [NLINE-1:0] pin_sync;
  logic [PW-1:0]    rd_val;

  gpio_addr_dec #(.AW(AW), .NPORT(NPORT), .IW(IW)) u_dec (
    .addr_i     (addr_i),
    .page_i     (page_q),
    .port_hit_o (port_hit),
    .port_idx_o (port_idx),
    .pend_hit_o (pend_hit),
    .pglk_hit_o (pglk_hit),
    .win_hit_o  (win_hit),
    .win_idx_o  (win_idx)
  );

  gpio_port_regs #(.NPORT(NPORT), .PW(PW), .IW(IW)) u_ports (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_i && port_hit),
    .idx_i   (port_idx),
    .wdata_i (wdata_i),
    .lock_i  (lock_q),
    .oe_o    (pad_oe_o)
  );

  gpio_sync #(.W(NLINE)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_sync)
  );

  // page in the top two bits, locks in the low bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= PG_NONE;
      lock_q <= '0;
    end else if (wr_i && pglk_hit) begin
      page_q <= page_e'(wdata_i[PW-1 -: 2]);
      lock_q <= wdata_i[NPORT-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    if (port_hit)      rd_val = ~pin_sync[port_idx*PW +: PW];
    else if (pend_hit) rd_val = pend_i;
    else if (pglk_hit) rd_val = {page_q, lock_q};
    else if (win_hit)  rd_val = pg_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
  end

  assign pin_sync_o = pin_sync;
  assign pg_wr_o    = wr_i && win_hit;
  assign pg_rd_o    = rd_i && win_hit;
  assign pg_sel_o   = page_q;
  assign pg_idx_o   = win_idx;
  assign pg_wdata_o = wdata_i;
endmodule

// File: rtl/gpio_paged_bank_chk.sv
module gpio_paged_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int NPORT = PORTS,
  parameter int PW    = PORT_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [AW-1:0]       addr_i,
  input logic [PW-1:0]       wdata_i,
  input logic                wr_i,
  input logic                rd_i,
  input logic [PW-1:0]       rdata_o,
  input logic [NPORT*PW-1:0] pad_oe_o,
  input logic                pg_wr_o,
  input logic                pg_rd_o,
  input logic [NPORT-1:0]    lock_q,
  input logic [1:0]          page_q
);
  localparam int IW = $clog2(NPORT);

  p_lock_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i < AW'(NPORT) && lock_q[addr_i[IW-1:0]]) |=> $stable(pad_oe_o));

  p_pglk_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == AW'(ADDR_PGLK)) |=> ({page_q, lock_q} == $past(wdata_i)));

  p_pend_ro_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == AW'(ADDR_PEND))
      |=> ($stable(pad_oe_o) && $stable(lock_q) && $stable(page_q)));

  p_win_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_wr_o || pg_rd_o) |-> (addr_i >= AW'(ADDR_WIN) && addr_i <= AW'(ADDR_LAST)
                              && page_q != 2'd0 && (wr_i || rd_i)));

  p_page0_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_q == 2'd0) |-> (!pg_wr_o && !pg_rd_o));

  p_high_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i > AW'(ADDR_LAST)) |=> (rdata_o == '0));

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind gpio_paged_bank gpio_paged_bank_chk #(.AW(AW), .NPORT(NPORT), .PW(PW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .rdata_o  (rdata_o),
  .pad_oe_o (pad_oe_o),
  .pg_wr_o  (pg_wr_o),
  .pg_rd_o  (pg_rd_o),
  .lock_q   (lock_q),
  .page_q   (page_q)
);

// File: tb/tb_gpio_paged_bank.sv
`timescale 1ns/1ps
module tb_gpio_paged_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic [47:0] pad_in, pad_oe, pin_sync, ext_low = '0;
  logic [7:0]  pend = '0, pg_rdata = '0;
  logic        pg_wr, pg_rd;
  logic [1:0]  pg_sel, pg_idx;
  logic [7:0]  pg_wdata;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  // open-drain loop: pad is low when the bank sinks it or the outside pulls it
  assign pad_in = ~(pad_oe | ext_low);

  gpio_paged_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_oe_o(pad_oe), .pin_sync_o(pin_sync),
    .pend_i(pend), .pg_rdata_i(pg_rdata), .pg_wr_o(pg_wr), .pg_rd_o(pg_rd),
    .pg_sel_o(pg_sel), .pg_idx_o(pg_idx), .pg_wdata_o(pg_wdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per sampled read
  always @(posedge clk) rd_seen <= rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("read-queue", 64'd1, 64'd0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {56'd0, rdata}, {56'd0, e});
      end
    end
  end

  // driver tasks start and end on a falling edge
  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [7:0] e, input string t);
    addr = a; rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #20000;
    check("watchdog", 64'd1, 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 oe", pad_oe, 48'h0);
    rd_reg(8'h07, 8'h00, "R1 pglk");
    rd_reg(8'h00, 8'h00, "R1/R3 released port reads 0");

    // R2 port writes drive the pads
    wr_reg(8'h00, 8'hA5);
    wr_reg(8'h05, 8'h3C);
    check("R2 port0", pad_oe[7:0], 48'hA5);
    check("R2 port5", pad_oe[47:40], 48'h3C);
    idle(3);
    rd_reg(8'h00, 8'hA5, "R3 port0");
    rd_reg(8'h05, 8'h3C, "R3 port5");

    // R3 synchronizer latency: two stale reads then the new value
    ext_low[23:16] = 8'hFF;
    rd_reg(8'h02, 8'h00, "R3 stale1");
    rd_reg(8'h02, 8'h00, "R3 stale2");
    rd_reg(8'h02, 8'hFF, "R3 fresh");
    check("R11 sync low", pin_sync[23:16], 48'h0);

    // R4, R5 lock
    wr_reg(8'h07, 8'h01);
    rd_reg(8'h07, 8'h01, "R4 lock readback");
    wr_reg(8'h00, 8'hFF);
    check("R5 locked port0", pad_oe[7:0], 48'hA5);
    wr_reg(8'h01, 8'h11);
    check("R5 unlocked port1", pad_oe[15:8], 48'h11);
    wr_reg(8'h07, 8'h00);
    rd_reg(8'h07, 8'h00, "R4 lock cleared");
    wr_reg(8'h00, 8'h00);
    check("R4 port0 writable again", pad_oe[7:0], 48'h00);

    // R6 pending register
    pend = 8'h05;
    rd_reg(8'h06, 8'h05, "R6 pending");
    wr_reg(8'h06, 8'hFF);
    check("R6 write ignored", pad_oe, 48'h3C00_0000_1100);
    rd_reg(8'h07, 8'h00, "R6 pglk untouched");

    // R8 page 0 window
    pg_rdata = 8'h77;
    addr = 8'h08; wdata = 8'h55; wr = 1'b1;
    #1 check("R8 no strobe", {63'd0, pg_wr}, 64'd0);
    @(negedge clk); wr = 1'b0;
    rd_reg(8'h09, 8'h00, "R8 page0 reads 0");

    // R7 paged window
    wr_reg(8'h07, 8'h80);
    addr = 8'h09; wdata = 8'h3E; wr = 1'b1;
    #1 check("R7 wr strobe", {pg_wr, pg_sel, pg_idx, pg_wdata}, {1'b1, 2'd2, 2'd1, 8'h3E});
    @(negedge clk); wr = 1'b0;
    addr = 8'h08; rd = 1'b1;
    exp_q.push_back(8'h77); tag_q.push_back("R7 paged read");
    #1 check("R7 rd strobe", {pg_rd, pg_sel, pg_idx}, {1'b1, 2'd2, 2'd0});
    @(negedge clk); rd = 1'b0;
    rd_reg(8'h0A, 8'h77, "R7 offset2 read");

    wr_reg(8'h07, 8'hC3);
    rd_reg(8'h07, 8'hC3, "R4 page3 locks");

    // R9 addresses above the map
    rd_reg(8'h0B, 8'h00, "R9 0x0B");
    rd_reg(8'hFF, 8'h00, "R9 0xFF");
    wr_reg(8'h0B, 8'hFF);
    check("R9 write ignored", pad_oe, 48'h3C00_0000_1100);
    rd_reg(8'h07, 8'hC3, "R9 pglk untouched");

    // R10 hold
    idle(3);
    check("R10 rdata hold", rdata, 48'hC3);

    // R11 exact two-stage latency
    ext_low[23:16] = 8'h00;
    @(negedge clk);
    check("R11 one edge", pin_sync[23:16], 48'h00);
    @(negedge clk);
    check("R11 two edges", pin_sync[23:16], 48'hFF);

    idle(3);
    check("queue drained", exp_q.size(), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule